// File: doc/BRIEF.md
# Windowed Core Activity Energy Meter

The block watches one processor core and its private cache. Each clock cycle the core reports which of four power states it is in, and the cache raises strobes for full-line reads, full-line writes, single-word reads and single-word writes. The block bins these events into eight counters over a fixed sampling window. At the end of each window it freezes the counts, raises a one-cycle completion pulse, and restarts counting without losing the event of the closing cycle.

After each window the block estimates the energy used in that window. It forms the sum of each of the eight counts times a 16-bit weight. The work is done by one multiplier over eight cycles, and a busy flag marks that time. The weights and the window length sit behind a simple write port. Software rewrites the weights whenever the operating frequency or supply voltage moves, because the active-state weight scales with frequency times the square of the voltage. The stall, idle and gated weights are that value times per-state constants. A write goes to a shadow copy and reaches the arithmetic only at a window boundary, so one window is never scored with a mix of old and new weights. The default window length is 163 cycles, which is about 1.3 µs at 125 MHz.

Top module: `coreEnergyWindow`

## Requirements
- R1: Every cycle outside reset adds one to exactly one of the four state bins: bin 0 for active (`stateVec` = 4'b0001), bin 1 for stall (4'b0010), bin 2 for idle (4'b0100) and bin 3 for power-gated (4'b1000). The four state counts of a window therefore add up to that window's length.
- R2: Each of the four cache strobes is counted in its own bin, and all four can count in the same cycle: bin 4 for line read, bin 5 for line write, bin 6 for word read and bin 7 for word write.
- R3: The window length in cycles comes from the `DEF_WIN` parameter at reset. Writing `cfgAddr` = 8 sets the length of the windows after the current one. Any value below 9, including values written there, is raised to 9.
- R4: In the last cycle of a window, all eight counts are copied to `latchedCounts`, and that copy includes the events of that last cycle. Bin k sits at bits [k*WIN_W +: WIN_W]. `windowDone` is high for exactly the one cycle after this. The live counts start again from zero with the next cycle.
- R5: `busy` is high for exactly the eight cycles that start with the `windowDone` cycle. When `busy` falls, `energy` holds the sum over the eight bins of the latched count times its weight. `energy` keeps that value until the next update.
- R6: Writing `cfgAddr` = k, for k from 0 to 7, sets the weight of bin k. A write takes effect for the window that starts after the current window ends. The energy of a window always uses the weights that were in force while that window ran.
- R7: If `stateVec` does not have exactly one bit set, the cycle is counted as active, and `stateErr` goes high and stays high until reset.
- R8: While `rstN` is low, all counts, `energy`, `windowDone`, `busy` and `stateErr` are zero, and the weights are zero.
- R9: Writes to `cfgAddr` 9 through 15 change neither the weights nor the window length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stateVec | input | 4 | One-hot core power state for this cycle |
| lineRd | input | 1 | Cache line read strobe |
| lineWr | input | 1 | Cache line write strobe |
| wordRd | input | 1 | Cache word read strobe |
| wordWr | input | 1 | Cache word write strobe |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | 4 | Configuration address (0-7 weights, 8 window length) |
| cfgData | input | 16 | Configuration write data |
| windowDone | output | 1 | One-cycle pulse after a window closes |
| busy | output | 1 | Energy calculation in progress |
| latchedCounts | output | 8*WIN_W | Counts of the last closed window, bin k at [k*WIN_W +: WIN_W] |
| energy | output | WIN_W+19 | Weighted energy of the last scored window |
| stateErr | output | 1 | Sticky flag for a state input that was not one-hot |

## Verification
A live counter that slips or misses an event shows up at the very next `windowDone` as a wrong latched count. For the state bins it also breaks the rule that their sum equals the window length. A window counter or length shadow that goes wrong moves the `windowDone` pulse, and the bench catches that in the same cycle by comparing it every cycle against a cycle-accurate arithmetic model. A weight bank that updates at the wrong boundary, or a multiply-accumulate step that uses the wrong index, gives a wrong `energy` eight cycles after the pulse. Windows in which the weights change mid-window expose which bank each window used.

// File: rtl/coreEnergyPkg.sv
package coreEnergyPkg;
  localparam int NUM_BINS  = 8;
  localparam int IDX_W     = 3;
  localparam int WEIGHT_W  = 16;
  localparam int ADDR_W    = 4;
  localparam int MIN_WIN   = 9;
  localparam logic [ADDR_W-1:0] LEN_ADDR = 4'd8;

  typedef enum logic [IDX_W-1:0] {
    BIN_ACTIVE  = 3'd0,
    BIN_STALL   = 3'd1,
    BIN_IDLE    = 3'd2,
    BIN_GATED   = 3'd3,
    BIN_LINE_RD = 3'd4,
    BIN_LINE_WR = 3'd5,
    BIN_WORD_RD = 3'd6,
    BIN_WORD_WR = 3'd7
  } binSel_t;

  typedef struct packed {
    logic             winEnd;
    logic             macStep;
    logic [IDX_W-1:0] macIdx;
    logic             macLast;
  } ctrlStrobes_t;
endpackage

// File: rtl/energyWinCtrl.sv
module energyWinCtrl
  import coreEnergyPkg::*;
#(
  parameter int WIN_W   = 16,
  parameter int DEF_WIN = 163
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [WEIGHT_W-1:0] cfgData,
  output ctrlStrobes_t        strobes,
  output logic                windowDone,
  output logic                busy
);
  localparam logic [WIN_W-1:0] MIN_LEN  = WIN_W'(MIN_WIN);
  localparam logic [WIN_W-1:0] DEF_LEN  = WIN_W'(DEF_WIN);
  localparam logic [WIN_W-1:0] RST_LEN  = (DEF_LEN < MIN_LEN) ? MIN_LEN : DEF_LEN;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BINS - 1);

  function automatic logic [WIN_W-1:0] clampLen(input logic [WIN_W-1:0] v);
    return (v < MIN_LEN) ? MIN_LEN : v;
  endfunction

  logic [WIN_W-1:0] shadowLen;
  logic [WIN_W-1:0] curLen;
  logic [WIN_W-1:0] winCnt;
  logic [IDX_W-1:0] macIdx;
  logic             winEnd;

  assign winEnd = (winCnt == curLen - 1'b1);

  // window timing and length shadow
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowLen  <= RST_LEN;
      curLen     <= RST_LEN;
      winCnt     <= '0;
      windowDone <= 1'b0;
    end else begin
      if (cfgWe && cfgAddr == LEN_ADDR)
        shadowLen <= clampLen(WIN_W'(cfgData));
      if (winEnd) begin
        winCnt <= '0;
        curLen <= shadowLen;
      end else begin
        winCnt <= winCnt + 1'b1;
      end
      windowDone <= winEnd;
    end
  end

  // eight-step multiply-accumulate sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      macIdx <= '0;
    end else if (winEnd) begin
      busy   <= 1'b1;
      macIdx <= '0;
    end else if (busy) begin
      macIdx <= macIdx + 1'b1;
      if (macIdx == LAST_IDX)
        busy <= 1'b0;
    end
  end

  always_comb begin
    strobes.winEnd  = winEnd;
    strobes.macStep = busy;
    strobes.macIdx  = macIdx;
    strobes.macLast = busy && (macIdx == LAST_IDX);
  end
endmodule

// File: rtl/energyWinDatapath.sv
module energyWinDatapath
  import coreEnergyPkg::*;
#(
  parameter int WIN_W = 16,
  localparam int CNT_W    = WIN_W,
  localparam int PROD_W   = CNT_W + WEIGHT_W,
  localparam int ENERGY_W = PROD_W + IDX_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [3:0]                stateVec,
  input  logic                      lineRd,
  input  logic                      lineWr,
  input  logic                      wordRd,
  input  logic                      wordWr,
  input  logic                      cfgWe,
  input  logic [ADDR_W-1:0]         cfgAddr,
  input  logic [WEIGHT_W-1:0]       cfgData,
  input  ctrlStrobes_t              strobes,
  output logic [NUM_BINS*CNT_W-1:0] latchedCounts,
  output logic [ENERGY_W-1:0]       energy,
  output logic                      stateErr
);
  logic [CNT_W-1:0]    liveCnt [NUM_BINS];
  logic [CNT_W-1:0]    latCnt  [NUM_BINS];
  logic [WEIGHT_W-1:0] shadowW [NUM_BINS];
  logic [WEIGHT_W-1:0] appliedW[NUM_BINS];
  logic [WEIGHT_W-1:0] macW    [NUM_BINS];
  logic [NUM_BINS-1:0] evt;
  logic                badState;
  logic [PROD_W-1:0]   product;
  logic [ENERGY_W-1:0] acc;

  // event decode: a malformed state is scored as active
  always_comb begin
    badState = ($countones(stateVec) != 1);
    evt[BIN_ACTIVE] = badState ? 1'b1 : stateVec[0];
    evt[BIN_STALL]  = badState ? 1'b0 : stateVec[1];
    evt[BIN_IDLE]   = badState ? 1'b0 : stateVec[2];
    evt[BIN_GATED]  = badState ? 1'b0 : stateVec[3];
    evt[BIN_LINE_RD] = lineRd;
    evt[BIN_LINE_WR] = lineWr;
    evt[BIN_WORD_RD] = wordRd;
    evt[BIN_WORD_WR] = wordWr;
  end

  for (genvar g = 0; g < NUM_BINS; g++) begin : gBin
    always_ff @(posedge clk) begin
      if (!rstN) begin
        liveCnt[g] <= '0;
        latCnt[g]  <= '0;
      end else if (strobes.winEnd) begin
        latCnt[g]  <= liveCnt[g] + CNT_W'(evt[g]);
        liveCnt[g] <= '0;
      end else begin
        liveCnt[g] <= liveCnt[g] + CNT_W'(evt[g]);
      end
    end

    // three weight banks: written, in force, being scored
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowW[g]  <= '0;
        appliedW[g] <= '0;
        macW[g]     <= '0;
      end else begin
        if (cfgWe && cfgAddr == ADDR_W'(g))
          shadowW[g] <= cfgData;
        if (strobes.winEnd) begin
          appliedW[g] <= shadowW[g];
          macW[g]     <= appliedW[g];
        end
      end
    end

    assign latchedCounts[g*CNT_W +: CNT_W] = latCnt[g];
  end

  assign product = PROD_W'(latCnt[strobes.macIdx]) * PROD_W'(macW[strobes.macIdx]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      energy <= '0;
    end else if (strobes.winEnd) begin
      acc <= '0;
    end else if (strobes.macStep) begin
      if (strobes.macLast) begin
        energy <= acc + ENERGY_W'(product);
        acc    <= '0;
      end else begin
        acc <= acc + ENERGY_W'(product);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         stateErr <= 1'b0;
    else if (badState) stateErr <= 1'b1;
  end
endmodule

// File: rtl/coreEnergyWindow.sv
module coreEnergyWindow
  import coreEnergyPkg::*;
#(
  parameter int WIN_W   = 16,
  parameter int DEF_WIN = 163,
  localparam int ENERGY_W = WIN_W + WEIGHT_W + IDX_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [3:0]                   stateVec,
  input  logic                         lineRd,
  input  logic                         lineWr,
  input  logic                         wordRd,
  input  logic                         wordWr,
  input  logic                         cfgWe,
  input  logic [3:0]                   cfgAddr,
  input  logic [15:0]                  cfgData,
  output logic                         windowDone,
  output logic                         busy,
  output logic [NUM_BINS*WIN_W-1:0]    latchedCounts,
  output logic [ENERGY_W-1:0]          energy,
  output logic                         stateErr
);
  ctrlStrobes_t strobes;

  energyWinCtrl #(.WIN_W(WIN_W), .DEF_WIN(DEF_WIN)) ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .strobes(strobes), .windowDone(windowDone), .busy(busy)
  );

  energyWinDatapath #(.WIN_W(WIN_W)) dpath (
    .clk(clk), .rstN(rstN), .stateVec(stateVec),
    .lineRd(lineRd), .lineWr(lineWr), .wordRd(wordRd), .wordWr(wordWr),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData), .strobes(strobes),
    .latchedCounts(latchedCounts), .energy(energy), .stateErr(stateErr)
  );
endmodule

// File: rtl/coreEnergyWindowChecker.sv
module coreEnergyWindowChecker
  import coreEnergyPkg::*;
#(
  parameter int WIN_W = 16,
  localparam int ENERGY_W = WIN_W + WEIGHT_W + IDX_W
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      windowDone,
  input logic                      busy,
  input logic [NUM_BINS*WIN_W-1:0] latchedCounts,
  input logic [ENERGY_W-1:0]       energy,
  input logic                      stateErr
);
  logic [WIN_W+1:0] stateSum;
  always_comb begin
    stateSum = '0;
    for (int i = 0; i < 4; i++)
      stateSum = stateSum + (WIN_W+2)'(latchedCounts[i*WIN_W +: WIN_W]);
  end

  assert_state_sum_R1: assert property (@(posedge clk) disable iff (!rstN)
    windowDone |-> stateSum >= (WIN_W+2)'(MIN_WIN));

  assert_counts_only_at_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(latchedCounts) |-> windowDone);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    windowDone |=> !windowDone);

  assert_busy_with_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    windowDone |-> busy);

  assert_energy_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $stable(energy));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    stateErr |=> stateErr);
endmodule

bind coreEnergyWindow coreEnergyWindowChecker #(.WIN_W(WIN_W)) chk (
  .clk(clk), .rstN(rstN), .windowDone(windowDone), .busy(busy),
  .latchedCounts(latchedCounts), .energy(energy), .stateErr(stateErr)
);

// File: tb/coreEnergyWindow_test.sv
module coreEnergyWindow_test;
  localparam int WIN_W = 16;
  localparam int DEF_WIN = 20;
  localparam int ENERGY_W = WIN_W + 19;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] stateVec = 4'b0001;
  logic lineRd = 0, lineWr = 0, wordRd = 0, wordWr = 0;
  logic cfgWe = 0;
  logic [3:0] cfgAddr = 0;
  logic [15:0] cfgData = 0;
  logic windowDone, busy, stateErr;
  logic [8*WIN_W-1:0] latchedCounts;
  logic [ENERGY_W-1:0] energy;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  coreEnergyWindow #(.WIN_W(WIN_W), .DEF_WIN(DEF_WIN)) uut (
    .clk(clk), .rstN(rstN), .stateVec(stateVec),
    .lineRd(lineRd), .lineWr(lineWr), .wordRd(wordRd), .wordWr(wordWr),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .windowDone(windowDone), .busy(busy), .latchedCounts(latchedCounts),
    .energy(energy), .stateErr(stateErr)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // arithmetic model of the requirements
  int mLen, mShadowLen, mWcnt, mBusyCnt, mCycle, mLastDone, mEndedLen;
  longint mLive[8], mLat[8], mShadowW[8], mAppW[8];
  longint mPending, mEnergy;
  bit mDone, mErr;

  always @(posedge clk) begin
    if (!rstN) begin
      mLen = DEF_WIN; mShadowLen = DEF_WIN; mWcnt = 0; mBusyCnt = 0;
      mPending = 0; mEnergy = 0; mDone = 0; mErr = 0; mCycle = 0;
      mLastDone = -1; mEndedLen = DEF_WIN;
      for (int i = 0; i < 8; i++) begin
        mLive[i] = 0; mLat[i] = 0; mShadowW[i] = 0; mAppW[i] = 0;
      end
    end else begin
      bit ev[8];
      bit isEnd;
      bit bad;
      bad = ($countones(stateVec) != 1);
      for (int i = 0; i < 4; i++) ev[i] = bad ? (i == 0) : stateVec[i];
      ev[4] = lineRd; ev[5] = lineWr; ev[6] = wordRd; ev[7] = wordWr;
      if (bad) mErr = 1;
      mCycle++;
      isEnd = (mWcnt == mLen - 1);
      if (mBusyCnt > 0) begin
        mBusyCnt--;
        if (mBusyCnt == 0) mEnergy = mPending;
      end
      if (isEnd) begin
        mPending = 0;
        for (int i = 0; i < 8; i++) begin
          mLat[i] = mLive[i] + ev[i];
          mLive[i] = 0;
          mPending += mLat[i] * mAppW[i];
          mAppW[i] = mShadowW[i];
        end
        mEndedLen = mLen;
        mLen = mShadowLen;
        mWcnt = 0;
        mBusyCnt = 8;
      end else begin
        for (int i = 0; i < 8; i++) mLive[i] += ev[i];
        mWcnt++;
      end
      mDone = isEnd;
      if (cfgWe && cfgAddr < 8) mShadowW[cfgAddr] = cfgData;
      if (cfgWe && cfgAddr == 8) mShadowLen = (cfgData < 9) ? 9 : cfgData;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R4 windowDone", windowDone, mDone);
      check("R5 busy", busy, mBusyCnt > 0);
      check("R5/R6 energy", energy, mEnergy);
      check("R7 stateErr", stateErr, mErr);
      if (mDone) begin
        longint sum;
        sum = 0;
        for (int i = 0; i < 4; i++) begin
          check("R1 state bin", latchedCounts[i*WIN_W +: WIN_W], mLat[i]);
          sum += latchedCounts[i*WIN_W +: WIN_W];
        end
        check("R1 state sum", sum, mEndedLen);
        for (int i = 4; i < 8; i++)
          check("R2 cache bin", latchedCounts[i*WIN_W +: WIN_W], mLat[i]);
        if (mLastDone >= 0)
          check("R3/R9 window period", mCycle - mLastDone, mEndedLen);
        mLastDone = mCycle;
      end
    end
  end

  task automatic step(input logic [3:0] st, input logic [3:0] str,
                      input logic we = 0, input logic [3:0] a = 0,
                      input logic [15:0] d = 0);
    stateVec = st;
    {wordWr, wordRd, lineWr, lineRd} = str;
    cfgWe = we; cfgAddr = a; cfgData = d;
    @(negedge clk);
  endtask

  task automatic sweep(input int n, input int seed);
    for (int k = 0; k < n; k++)
      step(4'b0001 << ((k * 3 + k / 5 + seed) % 4), 4'((k * 7 + seed) % 16));
  endtask

  initial begin
    @(negedge clk);
    repeat (4) @(negedge clk);
    // R8: reset state
    check("R8 done", windowDone, 0);
    check("R8 busy", busy, 0);
    check("R8 counts", latchedCounts == '0, 1);
    check("R8 energy", energy, 0);
    check("R8 err", stateErr, 0);
    rstN = 1'b1;

    // R6: load weights, then run windows
    for (int i = 0; i < 8; i++) step(4'b0001, 4'h0, 1, 4'(i), 16'(i * 1000 + 123));
    sweep(100, 1);
    // R6: change weights mid-window
    sweep(7, 2);
    for (int i = 0; i < 8; i++) step(4'b0010, 4'hF, 1, 4'(i), 16'(50000 - i * 3001));
    sweep(80, 3);

    // R3: clamp short length, R9: ignored addresses
    step(4'b0100, 4'h3, 1, 4'd8, 16'd3);
    for (int a = 9; a < 16; a++) step(4'b1000, 4'h5, 1, 4'(a), 16'hABCD);
    sweep(90, 4);
    step(4'b0001, 4'h0, 1, 4'd8, 16'd40);
    sweep(120, 5);

    // R5: largest weights with every strobe
    for (int i = 0; i < 8; i++) step(4'b1000, 4'hF, 1, 4'(i), 16'hFFFF);
    for (int k = 0; k < 130; k++) step(4'b1000, 4'hF);

    // R7: every state pattern, including malformed ones
    for (int r = 0; r < 4; r++)
      for (int v = 0; v < 16; v++) step(4'(v), 4'(v ^ r));
    sweep(100, 6);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule